// File: doc/BRIEF.md
# Countdown Timer With Done Latch

This block is a byte-wide countdown timer that a CPU programs through a small register window. Each qualifying tick moves the counter one step towards zero. When the counter gets to zero, a reload setting chooses what happens next. With reload on, the counter refills from a backup value on the following tick and keeps running. With reload off, it halts at zero. In both cases a sticky done flag is latched, and an interrupt request is raised whenever the interrupt enable is set and the flag is up.

Two behaviours of the flag need care from software. First, with reload off, a done flag that is already set stops the counter before its first step. Software must clear the flag before a one-shot run can start. There are two ways to clear it:
- write the flag's bit in control register B as 0, or
- write the whole of control register B as 0.

Second, the reset-done control is a level, not a pulse. It keeps the flag cleared for as long as it is held high. Meanwhile a halted counter sitting at zero keeps the interrupt request asserted. For this reason the reset-done control shares control register A with the interrupt enable, so that one write can drop the enable and raise the reset-done control together.

The tick comes from an external prescaler, which is not part of this block.

Top module: `cdt_timer`

## Requirements
- R1: After reset, reads give backup 0x00, control A 0x00 and count 0x00. Control B reads 0x01 because its zero bit is live. The interrupt request is low.
- R2: The register map is: address 0 = backup value, 1 = control A, 2 = count, 3 = control B. Register writes take effect at the clock edge on which they are strobed. Reads are combinational.
- R3: Control A bit 3 is the count enable. In a cycle where the tick is high, the count enable is 1 and counting is not inhibited, a nonzero count falls by one. With the tick low or the count enable at 0, the count does not change.
- R4: Control A bit 4 is the reload enable. With it at 0, a step from 1 to 0 sets the done flag (control B bit 3). Later ticks leave the count at 0.
- R5: With the reload enable at 0 and the done flag set, ticks do not change the count, even when the count is nonzero.
- R6: With the reload enable at 1 and the count at 0, a qualifying tick loads the backup value and sets the reload flag (control B bit 2). Counting then goes on even while the done flag is set.
- R7: A write to control B clears the done flag and the reload flag where their written bits are 0 and leaves them unchanged where their written bits are 1. Writing 0x00 therefore clears both. Control B bit 0 reads 1 exactly when the count is 0. After the done flag is cleared, counting resumes.
- R8: Control A bit 6 is the reset-done control and acts as a level. From the write that sets it, and for as long as it stays 1, the done flag reads 0, including on ticks that would otherwise set it.
- R9: Control A bit 7 is the interrupt enable. The interrupt request is high when the enable and the done flag are both set. It is also high when the enable is set, reset-done is held, reload is off and the count is 0. Otherwise it is low.
- R10: A single write to control A that clears the interrupt enable and sets the reset-done control drops the interrupt request, with effect from that write's edge.
- R11: A count write in the same cycle as a tick takes priority over the tick. If an expiry and a control B write fall in the same cycle, the expiry wins and the done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count step request from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong done flag has two visible effects in the cycle after the faulty edge:
- it shows up on control B bit 3 and on the interrupt request;
- with reload off, it makes the count freeze or keep falling against the expected sequence on the next tick.

A wrong inhibit decision or a wrong reload choice shows as a wrong count value one tick later. The scenarios follow the counter through both clearing paths, through a held reset-done control, and through same-cycle write/tick collisions, so that each of these divergences reaches a read within one or two cycles.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_BACKUP = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTLA   = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTLB   = 2'd3;

    // control A bit positions
    localparam int CA_IRQ_EN = 7;
    localparam int CA_CLR    = 6;
    localparam int CA_RELOAD = 4;
    localparam int CA_CNT_EN = 3;

    // control B bit positions
    localparam int CB_DONE   = 3;
    localparam int CB_RELOAD = 2;
    localparam int CB_ZERO   = 0;

    typedef struct packed {
        logic irq_en;
        logic clr_done;
        logic reload_en;
        logic count_en;
        logic done;
        logic reloaded;
    } cdt_ctl_t;
endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          count_en_i,
    input  logic          reload_en_i,
    input  logic          done_i,
    input  logic [DW-1:0] backup_i,
    input  logic          cnt_wr_i,
    input  logic [DW-1:0] cnt_wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic          expire_o,
    output logic          reload_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       inhibit;
    logic       step;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        reload_o = 1'b0;
        // one-shot mode: a latched done flag blocks even the first step
        inhibit  = ~reload_en_i & done_i;
        step     = tick_i & count_en_i & ~inhibit;
        if (cnt_wr_i) begin
            s_d.cnt = cnt_wdata_i;
        end else if (step) begin
            if (s_q.cnt == '0) begin
                if (reload_en_i) begin
                    s_d.cnt  = backup_i;
                    reload_o = 1'b1;
                end else begin
                    expire_o = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt - ONE;
                if (s_q.cnt == ONE) begin
                    expire_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
    import cdt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_bkp_i,
    input  logic          wr_cta_i,
    input  logic          wr_ctb_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          a_irq_en_i,
    input  logic          a_clr_i,
    input  logic          a_reload_i,
    input  logic          a_cnt_en_i,
    input  logic          b_done_i,
    input  logic          b_reloaded_i,
    input  logic          expire_i,
    input  logic          reload_evt_i,
    output cdt_ctl_t      ctl_o,
    output logic [DW-1:0] backup_o
);
    typedef struct packed {
        cdt_ctl_t      c;
        logic [DW-1:0] backup;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_bkp_i) s_d.backup = wdata_i;
        if (wr_cta_i) begin
            s_d.c.irq_en    = a_irq_en_i;
            s_d.c.clr_done  = a_clr_i;
            s_d.c.reload_en = a_reload_i;
            s_d.c.count_en  = a_cnt_en_i;
        end
        if (wr_ctb_i) begin
            s_d.c.done     = s_q.c.done & b_done_i;
            s_d.c.reloaded = s_q.c.reloaded & b_reloaded_i;
        end
        if (reload_evt_i) s_d.c.reloaded = 1'b1;
        if (expire_i)     s_d.c.done     = 1'b1;
        // level reset-done, effective from the write that raises it
        if (s_d.c.clr_done) s_d.c.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o    = s_q.c;
    assign backup_o = s_q.backup;
endmodule

// File: rtl/cdt_outmux.sv
module cdt_outmux
    import cdt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  cdt_ctl_t          ctl_i,
    input  logic [DW-1:0]     backup_i,
    input  logic [DW-1:0]     cnt_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o
);
    logic       zero;
    logic [7:0] ctla_byte;
    logic [7:0] ctlb_byte;

    always_comb begin
        zero      = (cnt_i == '0);
        ctla_byte = '0;
        ctla_byte[CA_IRQ_EN] = ctl_i.irq_en;
        ctla_byte[CA_CLR]    = ctl_i.clr_done;
        ctla_byte[CA_RELOAD] = ctl_i.reload_en;
        ctla_byte[CA_CNT_EN] = ctl_i.count_en;
        ctlb_byte = '0;
        ctlb_byte[CB_DONE]   = ctl_i.done;
        ctlb_byte[CB_RELOAD] = ctl_i.reloaded;
        ctlb_byte[CB_ZERO]   = zero;
        unique case (addr_i)
            A_BACKUP: rdata_o = backup_i;
            A_CTLA:   rdata_o = DW'(ctla_byte);
            A_COUNT:  rdata_o = cnt_i;
            default:  rdata_o = DW'(ctlb_byte);
        endcase
        irq_o = ctl_i.irq_en &
                (ctl_i.done | (ctl_i.clr_done & ~ctl_i.reload_en & zero));
    end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o
);
    logic          wr_bkp, wr_cta, wr_cnt, wr_ctb;
    logic          expire, reload_evt;
    logic [DW-1:0] cnt, backup;
    cdt_ctl_t      ctl;

    always_comb begin
        wr_bkp = wr_en_i && (addr_i == A_BACKUP);
        wr_cta = wr_en_i && (addr_i == A_CTLA);
        wr_cnt = wr_en_i && (addr_i == A_COUNT);
        wr_ctb = wr_en_i && (addr_i == A_CTLB);
    end

    cdt_ctrl #(.DW(DW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_bkp_i     (wr_bkp),
        .wr_cta_i     (wr_cta),
        .wr_ctb_i     (wr_ctb),
        .wdata_i      (wdata_i),
        .a_irq_en_i   (wdata_i[CA_IRQ_EN]),
        .a_clr_i      (wdata_i[CA_CLR]),
        .a_reload_i   (wdata_i[CA_RELOAD]),
        .a_cnt_en_i   (wdata_i[CA_CNT_EN]),
        .b_done_i     (wdata_i[CB_DONE]),
        .b_reloaded_i (wdata_i[CB_RELOAD]),
        .expire_i     (expire),
        .reload_evt_i (reload_evt),
        .ctl_o        (ctl),
        .backup_o     (backup)
    );

    cdt_counter #(.DW(DW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .count_en_i  (ctl.count_en),
        .reload_en_i (ctl.reload_en),
        .done_i      (ctl.done),
        .backup_i    (backup),
        .cnt_wr_i    (wr_cnt),
        .cnt_wdata_i (wdata_i),
        .cnt_o       (cnt),
        .expire_o    (expire),
        .reload_o    (reload_evt)
    );

    cdt_outmux #(.DW(DW)) u_out (
        .addr_i   (addr_i),
        .ctl_i    (ctl),
        .backup_i (backup),
        .cnt_i    (cnt),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          wr_en_i,
    input logic [1:0]    addr_i,
    input logic          irq_o,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] backup,
    input logic          done,
    input logic          clr_done,
    input logic          reload_en,
    input logic          count_en,
    input logic          irq_en
);
    logic cnt_wr, cta_wr, ctb_wr;
    assign cnt_wr = wr_en_i && (addr_i == 2'd2);
    assign cta_wr = wr_en_i && (addr_i == 2'd1);
    assign ctb_wr = wr_en_i && (addr_i == 2'd3);

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_en && !(done && !reload_en) && cnt != '0 && !cnt_wr)
        |=> cnt == $past(cnt) - DW'(1));

    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr) |=> $stable(cnt));

    a_r4_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !reload_en && !cnt_wr) |=> cnt == '0);

    a_r5_done_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload_en && !cnt_wr) |=> $stable(cnt));

    a_r6_reload_backup: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_en && reload_en && cnt == '0 && !cnt_wr)
        |=> cnt == $past(backup));

    a_r8_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !cta_wr) |=> !done);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en);

    a_r9_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && done) |-> irq_o);

    a_r11_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_en && !clr_done && !cta_wr && !cnt_wr && ctb_wr
         && cnt == DW'(1)) |=> done);
endmodule

bind cdt_timer cdt_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .irq_o     (irq_o),
    .cnt       (cnt),
    .backup    (backup),
    .done      (ctl.done),
    .clr_done  (ctl.clr_done),
    .reload_en (ctl.reload_en),
    .count_en  (ctl.count_en),
    .irq_en    (ctl.irq_en)
);

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    addr_i = 2'd0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [1:0]    q_addr[$];
    logic [DW-1:0] q_data[$];
    logic          q_irq[$];
    string         q_tag[$];

    always #4 clk = ~clk;

    cdt_timer #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        cyc();
        wr_en_i = 1'b0;
    endtask

    task automatic tk(input int n);
        tick_i = 1'b1;
        repeat (n) cyc();
        tick_i = 1'b0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [DW-1:0] d,
                       input logic irq, input string tag);
        addr_i = a;
        q_addr.push_back(a); q_data.push_back(d);
        q_irq.push_back(irq); q_tag.push_back(tag);
        cyc();
    endtask

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_addr.size() > 0) begin
                logic [1:0]    a;
                logic [DW-1:0] d;
                logic          ir;
                string         t;
                a = q_addr.pop_front(); d = q_data.pop_front();
                ir = q_irq.pop_front(); t = q_tag.pop_front();
                n_cmp++;
                if (rdata_o !== d || irq_o !== ir) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                             t, a, rdata_o, irq_o, d, ir);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(2'd0, 8'h00, 1'b0, "R1 backup");
        chk(2'd1, 8'h00, 1'b0, "R1 ctlA");
        chk(2'd2, 8'h00, 1'b0, "R1 count");
        chk(2'd3, 8'h01, 1'b0, "R1 ctlB");
        // R2 map
        wr(2'd0, 8'h05); wr(2'd1, 8'h08); wr(2'd2, 8'h03);
        chk(2'd0, 8'h05, 1'b0, "R2 backup");
        chk(2'd1, 8'h08, 1'b0, "R2 ctlA");
        chk(2'd2, 8'h03, 1'b0, "R2 count");
        // R3 gating
        wr(2'd1, 8'h00); tk(2);
        chk(2'd2, 8'h03, 1'b0, "R3 enable off");
        wr(2'd1, 8'h08); cyc(); cyc();
        chk(2'd2, 8'h03, 1'b0, "R3 no tick");
        tk(1);
        chk(2'd2, 8'h02, 1'b0, "R3 step");
        // R4 one-shot expiry
        tk(2);
        chk(2'd2, 8'h00, 1'b0, "R4 count zero");
        chk(2'd3, 8'h09, 1'b0, "R4 done set");
        tk(3);
        chk(2'd2, 8'h00, 1'b0, "R4 stays zero");
        // R5 inhibit
        wr(2'd2, 8'h04); tk(3);
        chk(2'd2, 8'h04, 1'b0, "R5 inhibited");
        chk(2'd3, 8'h08, 1'b0, "R5 done held");
        // R7 clear by bit write, resume
        wr(2'd3, 8'hF7);
        chk(2'd3, 8'h00, 1'b0, "R7 bit clear");
        tk(1);
        chk(2'd2, 8'h03, 1'b0, "R7 resume after bit clear");
        tk(3);
        chk(2'd3, 8'h09, 1'b0, "R4 expiry again");
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h00);
        chk(2'd3, 8'h00, 1'b0, "R7 byte clear");
        tk(1);
        chk(2'd2, 8'h01, 1'b0, "R7 resume after byte clear");
        tk(1);
        wr(2'd3, 8'hFF);
        chk(2'd3, 8'h09, 1'b0, "R7 ones keep done");
        // R9, R10, R8
        wr(2'd1, 8'h88);
        chk(2'd3, 8'h09, 1'b1, "R9 irq from done");
        wr(2'd1, 8'h48);
        chk(2'd3, 8'h01, 1'b0, "R10 one write drops irq");
        wr(2'd1, 8'hC8);
        chk(2'd3, 8'h01, 1'b1, "R9 held reset-done irq");
        tk(2);
        chk(2'd3, 8'h01, 1'b1, "R8 done held clear");
        wr(2'd1, 8'h88);
        chk(2'd3, 8'h01, 1'b0, "R9 released");
        // R6 reload
        wr(2'd1, 8'h98); wr(2'd2, 8'h01); tk(1);
        chk(2'd3, 8'h09, 1'b1, "R6 done on zero");
        tk(1);
        chk(2'd2, 8'h05, 1'b1, "R6 reloaded value");
        chk(2'd3, 8'h0C, 1'b1, "R6 reload flag");
        tk(2);
        chk(2'd2, 8'h03, 1'b1, "R6 keeps counting");
        // R11 collisions
        tick_i = 1'b1; wr(2'd2, 8'h07); tick_i = 1'b0;
        chk(2'd2, 8'h07, 1'b1, "R11 write beats tick");
        wr(2'd2, 8'h01); wr(2'd3, 8'h00);
        chk(2'd3, 8'h00, 1'b0, "R7 clear both flags");
        tick_i = 1'b1; wr(2'd3, 8'h00); tick_i = 1'b0;
        chk(2'd3, 8'h09, 1'b1, "R11 expiry beats clear");
        cyc(); cyc();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule